// File: doc/BRIEF.md
# Framebuffer Register Access Port

This block is the processor-facing register front end of a video controller that stores four bits per pixel. A simple synchronous bus selects one of eight word offsets, six of them in use. Through these the processor loads a read pointer and a write pointer into video memory. It moves pixel words through a single data window. It picks a palette slot and writes a 12-bit colour into it. It reads a status word that reports the display mode and whether the scanout logic is in vertical blank.

The two video memory pointers are kept apart. A read through the data window uses the read pointer and then advances it by one. A write through the window uses the write pointer and then advances that one only. This lets software stream words in either direction without reloading a pointer. A read-modify-write of one word loads both pointers with the same address. The memory array, display timing and pixel generation sit outside this block. It drives a synchronous memory port with a one-cycle read latency and a palette write port.

Top module: `fbreg_port`

## Requirements
- R1: After a synchronous active-high reset, both pointers and the palette slot select are zero, `bus_rvalid` is low, and no memory or palette strobe is active.
- R2: A write to offset 0 loads the read pointer, and a write to offset 1 loads the write pointer, from `bus_wdata[15:0]`; upper bits are dropped. Reading offset 0 or 1 returns that pointer zero-extended to 32 bits.
- R3: A read of offset 2 asserts `vm_re` with `vm_raddr` equal to the read pointer in the request cycle. In the next cycle `bus_rdata` equals `vm_rdata`. The read pointer then holds its old value plus one.
- R4: A write to offset 2 asserts `vm_we` in the request cycle, with `vm_waddr` equal to the write pointer and `vm_wdata` equal to `bus_wdata`. The write pointer then holds its old value plus one.
- R5: A data-window read leaves the write pointer unchanged, and a data-window write leaves the read pointer unchanged.
- R6: Both pointers are 16 bits wide and step from 0xFFFF to 0x0000.
- R7: A write to offset 3 selects palette slot `bus_wdata[3:0]` (0 to 15); the other bits are ignored. The selected slot is presented on `pal_idx`.
- R8: A write to offset 4 pulses `pal_we` for one cycle, with `pal_idx` equal to the selected slot and `pal_rgb` equal to `bus_wdata[11:0]`. In that field red is bits 11:8, green 7:4 and blue 3:0.
- R9: Every read receives `bus_rvalid` exactly one cycle after the request, and writes receive none. Reads of offsets 3, 4, 6 and 7 return zero.
- R10: A read of offset 5 returns the mode code 1 (640x400, 4 bits per pixel) in bits 31:28 and the sampled `vblank` in bit 0, with all other bits zero. A write to offset 5 produces no strobe and changes no pointer.
- R11: `vm_re`, `vm_we` and `pal_we` are asserted only in the cycle of a selected access to their own offset and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after a read |
| vm_re | output | 1 | Video memory read enable |
| vm_raddr | output | 16 | Video memory read address |
| vm_rdata | input | 32 | Video memory read data, one cycle after vm_re |
| vm_we | output | 1 | Video memory write enable |
| vm_waddr | output | 16 | Video memory write address |
| vm_wdata | output | 32 | Video memory write data |
| pal_we | output | 1 | Palette slot write strobe |
| pal_idx | output | 4 | Selected palette slot |
| pal_rgb | output | 12 | Colour to write, red/green/blue nibbles |
| vblank | input | 1 | Vertical blank flag from scanout |

## Verification
The hardest case to reach is the pointer wrap from 0xFFFF to zero, because each pointer moves one step per data access. Walking there through the ports would take 65,536 accesses. The bench instead loads each pointer directly with 0xFFFF, performs one data access, and reads the pointer back. Independence of the two pointers is shown the same way: a stream of reads and writes is interleaved, both pointers are read back, and a read-modify-write ends with the stored value read through the other pointer.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 16;
    localparam int OFF_W     = 3;
    localparam int PAL_SLOTS = 16;
    localparam int PAL_IDX_W = $clog2(PAL_SLOTS);
    localparam int CH_W      = 4;
    localparam int RGB_W     = 3 * CH_W;
    localparam int MODE_W    = 4;
    localparam logic [MODE_W-1:0] MODE_ID = 4'd1;

    localparam logic [OFF_W-1:0] OFF_RPTR = 3'd0;
    localparam logic [OFF_W-1:0] OFF_WPTR = 3'd1;
    localparam logic [OFF_W-1:0] OFF_DATA = 3'd2;
    localparam logic [OFF_W-1:0] OFF_PSEL = 3'd3;
    localparam logic [OFF_W-1:0] OFF_PDAT = 3'd4;
    localparam logic [OFF_W-1:0] OFF_STAT = 3'd5;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic rptr_ld;
        logic wptr_ld;
        logic mem_rd;
        logic mem_wr;
        logic psel_ld;
        logic pal_wr;
        logic rd_req;
    } fb_cmd_t;

    function automatic logic [DATA_W-1:0] status_word(input logic vb);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1 -: MODE_W] = MODE_ID;
        w[0] = vb;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] widen_ptr(input logic [ADDR_W-1:0] p);
        return {{(DATA_W-ADDR_W){1'b0}}, p};
    endfunction

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
    import fbreg_pkg::*;
(
    input  logic             sel,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    output fb_cmd_t          cmd
);
    always_comb begin
        cmd         = '0;
        cmd.rd_req  = sel && !we;
        cmd.rptr_ld = sel &&  we && (off == OFF_RPTR);
        cmd.wptr_ld = sel &&  we && (off == OFF_WPTR);
        cmd.mem_wr  = sel &&  we && (off == OFF_DATA);
        cmd.mem_rd  = sel && !we && (off == OFF_DATA);
        cmd.psel_ld = sel &&  we && (off == OFF_PSEL);
        cmd.pal_wr  = sel &&  we && (off == OFF_PDAT);
    end

    always_comb begin
        a_onehot_r11: assert ($onehot0({cmd.rptr_ld, cmd.wptr_ld, cmd.mem_rd,
                                        cmd.mem_wr, cmd.psel_ld, cmd.pal_wr}));
    end
endmodule

// File: rtl/fbreg_latch.sv
module fbreg_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + ONE;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> q == $past(ld_val));
    p_step_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld) |=> q == W'($past(q) + ONE));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/fbreg_rsp.sv
module fbreg_rsp
    import fbreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              rd_mem,
    input  logic [DATA_W-1:0] reg_word,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic              from_mem_q;
    logic [DATA_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid     <= 1'b0;
            from_mem_q <= 1'b0;
            reg_q      <= '0;
        end else begin
            rvalid     <= rd_req;
            from_mem_q <= rd_mem;
            reg_q      <= rd_req ? reg_word : '0;
        end
    end

    assign rdata = from_mem_q ? mem_word : reg_q;

    p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rvalid);
    p_no_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rvalid);
endmodule

// File: rtl/fbreg_port.sv
module fbreg_port
    import fbreg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PAL_IDX_W,
    parameter int CW = RGB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rvalid,
    output logic          vm_re,
    output logic [AW-1:0] vm_raddr,
    input  logic [DW-1:0] vm_rdata,
    output logic          vm_we,
    output logic [AW-1:0] vm_waddr,
    output logic [DW-1:0] vm_wdata,
    output logic          pal_we,
    output logic [PW-1:0] pal_idx,
    output logic [CW-1:0] pal_rgb,
    input  logic          vblank
);
    fb_cmd_t           cmd;
    logic [AW-1:0]     rptr, wptr;
    logic [PW-1:0]     slot_q;
    logic [DW-1:0]     reg_word;
    rgb_t              colour;

    fbreg_decode u_dec (
        .sel (bus_sel),
        .we  (bus_we),
        .off (bus_addr),
        .cmd (cmd)
    );

    fbreg_latch #(.W(AW)) u_rptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (cmd.rptr_ld),
        .ld_val (bus_wdata[AW-1:0]),
        .inc    (cmd.mem_rd),
        .q      (rptr)
    );

    fbreg_latch #(.W(AW)) u_wptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (cmd.wptr_ld),
        .ld_val (bus_wdata[AW-1:0]),
        .inc    (cmd.mem_wr),
        .q      (wptr)
    );

    always_ff @(posedge clk) begin
        if (rst)              slot_q <= '0;
        else if (cmd.psel_ld) slot_q <= bus_wdata[PW-1:0];
    end

    always_comb begin
        unique case (bus_addr)
            OFF_RPTR: reg_word = widen_ptr(rptr);
            OFF_WPTR: reg_word = widen_ptr(wptr);
            OFF_STAT: reg_word = status_word(vblank);
            default:  reg_word = '0;
        endcase
    end

    fbreg_rsp u_rsp (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (cmd.rd_req),
        .rd_mem   (cmd.mem_rd),
        .reg_word (reg_word),
        .mem_word (vm_rdata),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    assign colour   = rgb_t'(bus_wdata[CW-1:0]);
    assign vm_re    = cmd.mem_rd;
    assign vm_raddr = rptr;
    assign vm_we    = cmd.mem_wr;
    assign vm_waddr = wptr;
    assign vm_wdata = bus_wdata;
    assign pal_we   = cmd.pal_wr;
    assign pal_idx  = slot_q;
    assign pal_rgb  = colour;

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({vm_re, vm_we, pal_we}) <= 1);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> !(vm_re || vm_we || pal_we));
    p_rd_indep_r5: assert property (@(posedge clk) disable iff (rst)
        vm_re |=> wptr == $past(wptr));
    p_wr_indep_r5: assert property (@(posedge clk) disable iff (rst)
        vm_we |=> rptr == $past(rptr));
    p_stat_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == OFF_STAT) |=>
            (rptr == $past(rptr) && wptr == $past(wptr) && slot_q == $past(slot_q)));
endmodule

// File: tb/fbreg_port_tb.sv
module fbreg_port_tb;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic        we;
        logic [2:0]  off;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 32'h0000_0010, 1'b0, 32'h0},          // load write pointer
        '{1'b1, 3'd2, 32'hAAAA_0001, 1'b0, 32'h0},          // mem[16]
        '{1'b1, 3'd2, 32'hBBBB_0002, 1'b0, 32'h0},          // mem[17]
        '{1'b0, 3'd1, 32'h0,         1'b1, 32'h0000_0012},  // write ptr advanced twice
        '{1'b1, 3'd0, 32'h0000_0010, 1'b0, 32'h0},          // load read pointer
        '{1'b0, 3'd2, 32'h0,         1'b1, 32'hAAAA_0001},
        '{1'b0, 3'd2, 32'h0,         1'b1, 32'hBBBB_0002},
        '{1'b0, 3'd0, 32'h0,         1'b1, 32'h0000_0012},  // read ptr advanced twice
        '{1'b0, 3'd1, 32'h0,         1'b1, 32'h0000_0012},  // write ptr untouched by reads
        '{1'b1, 3'd0, 32'hFFFF_0011, 1'b0, 32'h0},          // upper bits dropped
        '{1'b0, 3'd0, 32'h0,         1'b1, 32'h0000_0011},
        '{1'b0, 3'd3, 32'h0,         1'b1, 32'h0},          // write-only reads zero
        '{1'b0, 3'd4, 32'h0,         1'b1, 32'h0},
        '{1'b0, 3'd6, 32'h0,         1'b1, 32'h0},
        '{1'b0, 3'd7, 32'h0,         1'b1, 32'h0},
        '{1'b1, 3'd0, 32'h0000_0010, 1'b0, 32'h0},          // read-modify-write of word 16
        '{1'b1, 3'd1, 32'h0000_0010, 1'b0, 32'h0},
        '{1'b0, 3'd2, 32'h0,         1'b1, 32'hAAAA_0001},
        '{1'b1, 3'd2, 32'h1234_5678, 1'b0, 32'h0},
        '{1'b1, 3'd0, 32'h0000_0010, 1'b0, 32'h0},
        '{1'b0, 3'd2, 32'h0,         1'b1, 32'h1234_5678}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        vm_re, vm_we, pal_we;
    logic [15:0] vm_raddr, vm_waddr;
    logic [31:0] vm_rdata = '0, vm_wdata;
    logic [3:0]  pal_idx;
    logic [11:0] pal_rgb;
    logic        vblank = 1'b0;

    logic [31:0] mem [64];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // snapshot of the request cycle
    logic        s_re, s_we, s_pwe;
    logic [15:0] s_raddr, s_waddr;
    logic [31:0] s_wdata;
    logic [3:0]  s_idx;
    logic [11:0] s_rgb;
    logic        r_valid;
    logic [31:0] r_data;

    always #(CLK_P/2) clk = ~clk;

    fbreg_port u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .vm_re(vm_re), .vm_raddr(vm_raddr),
        .vm_rdata(vm_rdata), .vm_we(vm_we), .vm_waddr(vm_waddr),
        .vm_wdata(vm_wdata), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_rgb(pal_rgb), .vblank(vblank)
    );

    // external synchronous memory model, one-cycle read latency
    always @(posedge clk) begin
        if (vm_re) vm_rdata <= mem[vm_raddr[5:0]];
        if (vm_we) mem[vm_waddr[5:0]] <= vm_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [2:0] off, input logic [31:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = off; bus_wdata = wd;
        #1;
        s_re = vm_re; s_we = vm_we; s_pwe = pal_we;
        s_raddr = vm_raddr; s_waddr = vm_waddr; s_wdata = vm_wdata;
        s_idx = pal_idx; s_rgb = pal_rgb;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1;
        r_valid = bus_rvalid; r_data = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
        chk("R1 strobes after reset", {29'b0, vm_re, vm_we, pal_we}, 32'h0);
        chk("R1 palette slot after reset", {28'b0, pal_idx}, 32'h0);
        bus_op(1'b0, 3'd0, '0);
        chk("R1 read pointer after reset", r_data, 32'h0);
        bus_op(1'b0, 3'd1, '0);
        chk("R1 write pointer after reset", r_data, 32'h0);
        chk("R11 register read gives no memory strobe", {31'b0, s_re}, 32'h0);

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].we, VEC[i].off, VEC[i].wd);
            chk($sformatf("R9 table vector %0d rvalid", i), {31'b0, r_valid}, {31'b0, ~VEC[i].we});
            if (VEC[i].chk)
                chk($sformatf("R2/R3/R5 table vector %0d data", i), r_data, VEC[i].exp);
        end

        // R3 / R4 addresses on the memory port
        bus_op(1'b1, 3'd0, 32'h0000_0005);
        bus_op(1'b0, 3'd2, '0);
        chk("R3 vm_re on data read", {31'b0, s_re}, 32'h1);
        chk("R3 vm_raddr equals read pointer", {16'b0, s_raddr}, 32'h5);
        bus_op(1'b1, 3'd1, 32'h0000_0020);
        bus_op(1'b1, 3'd2, 32'hCAFE_F00D);
        chk("R4 vm_we on data write", {31'b0, s_we}, 32'h1);
        chk("R4 vm_waddr equals write pointer", {16'b0, s_waddr}, 32'h20);
        chk("R4 vm_wdata equals bus data", s_wdata, 32'hCAFE_F00D);
        chk("R11 no read strobe on write", {31'b0, s_re}, 32'h0);
        bus_op(1'b0, 3'd1, '0);
        chk("R4 write pointer advanced", r_data, 32'h21);
        bus_op(1'b0, 3'd0, '0);
        chk("R5 read pointer untouched by write", r_data, 32'h6);

        // R6 wrap of both pointers
        bus_op(1'b1, 3'd1, 32'h0000_FFFF);
        bus_op(1'b1, 3'd2, 32'h0000_0077);
        chk("R6 write at 0xFFFF", {16'b0, s_waddr}, 32'h0000_FFFF);
        bus_op(1'b0, 3'd1, '0);
        chk("R6 write pointer wrapped", r_data, 32'h0);
        bus_op(1'b1, 3'd0, 32'h0000_FFFF);
        bus_op(1'b0, 3'd2, '0);
        chk("R6 read at 0xFFFF", {16'b0, s_raddr}, 32'h0000_FFFF);
        bus_op(1'b0, 3'd0, '0);
        chk("R6 read pointer wrapped", r_data, 32'h0);

        // R7 / R8 palette
        bus_op(1'b1, 3'd3, 32'hFFFF_FFF7);
        bus_op(1'b1, 3'd4, 32'hFFFF_FABC);
        chk("R8 pal_we on palette data write", {31'b0, s_pwe}, 32'h1);
        chk("R7 slot from bits 3:0", {28'b0, s_idx}, 32'h7);
        chk("R8 colour bits 11:0", {20'b0, s_rgb}, 32'h0000_0ABC);
        chk("R11 no memory strobe on palette write", {30'b0, s_re, s_we}, 32'h0);
        @(negedge clk); #1;
        chk("R8 pal_we lasts one cycle", {31'b0, pal_we}, 32'h0);
        bus_op(1'b1, 3'd3, 32'h0000_000F);
        bus_op(1'b1, 3'd4, 32'h0000_0123);
        chk("R7 slot 15", {28'b0, s_idx}, 32'hF);
        chk("R8 colour for slot 15", {20'b0, s_rgb}, 32'h0000_0123);

        // R10 status word
        vblank = 1'b1;
        bus_op(1'b0, 3'd5, '0);
        chk("R10 status in blank", r_data, 32'h1000_0001);
        vblank = 1'b0;
        bus_op(1'b0, 3'd5, '0);
        chk("R10 status outside blank", r_data, 32'h1000_0000);
        bus_op(1'b1, 3'd5, 32'hFFFF_FFFF);
        chk("R10 write to status gives no strobe", {29'b0, s_re, s_we, s_pwe}, 32'h0);
        chk("R9 no rvalid for a write", {31'b0, r_valid}, 32'h0);
        bus_op(1'b0, 3'd0, '0);
        chk("R10 read pointer kept", r_data, 32'h0);
        bus_op(1'b0, 3'd1, '0);
        chk("R10 write pointer kept", r_data, 32'h0);
        bus_op(1'b1, 3'd4, 32'h0000_0456);
        chk("R10 palette slot kept", {28'b0, s_idx}, 32'hF);

        // R11 idle bus with write data toggling
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R11 idle bus gives no strobe", {29'b0, vm_re, vm_we, pal_we}, 32'h0);
        bus_we = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule